// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps three statistics counters for an Ethernet MAC. The first is a 64-bit count of good received octets and the second a 64-bit count of good transmitted octets. The third is a 32-bit count of receive frames that arrived while the host had no free buffer. The receive and transmit paths each give one end-of-frame strobe per frame. With the strobe come the frame's byte count, measured from the first destination-address byte through the last CRC byte, and a set of qualifier flags. The block decides from those flags whether each counter takes the frame.

Software reads the counters through a 32-bit read port. Each octet counter has one word address for its low half and one for its high half. Reading a high half returns that half and clears the whole 64-bit counter. Reading a low half only returns data. The no-buffers counter clears when it is read. No counter ever wraps: a counter that reaches its maximum stays at all ones until it is cleared.

Top module: `mac_stat_bank`

## Requirements
- R1: After a synchronous active-high reset, every counter reads as zero at every mapped address.
- R2: The word addresses are 0 = receive octets low, 1 = receive octets high, 2 = transmit octets low, 3 = transmit octets high, 4 = no-buffers count. `rd_data` carries the addressed word in the cycle after the cycle in which `rd_en` is high, and is zero in every other cycle. Addresses 5 to 7 return zero and change no counter.
- R3: A read of address 1 or 3 returns the high half as it was before the read and clears the whole 64-bit counter. A read of address 0 or 2 leaves the counter unchanged.
- R4: When a high-half read and a counted frame fall in the same cycle, the counter afterwards holds that frame's length, so the frame is not lost.
- R5: A counter holds at all ones once it gets there. An addition that would pass the maximum gives all ones and never a wrapped value.
- R6: The receive octet counter adds `rx_len` on an `rx_eof` strobe when `rx_enable`, `rx_good` and `rx_addr_pass` are all 1 and `rx_missed` and `rx_fc` are both 0. Frames to the manageability path come in as ordinary qualified frames and are counted the same way.
- R7: A receive frame that is bad, filtered out, missed or a flow-control frame, or that arrives while `rx_enable` is 0, leaves the receive octet counter unchanged.
- R8: The transmit octet counter adds `tx_len` on a `tx_eof` strobe only when `tx_enable` and `tx_good` are 1, `tx_fc` is 0 and `tx_len` is at least 64.
- R9: The no-buffers counter adds one for each `rx_eof` that has `rx_enable` = 1, `rx_buf_avail` = 0 and `rx_fc` = 0, whatever the good and filter flags are. A read of address 4 clears it, and it saturates like the octet counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive enabled |
| tx_enable | input | 1 | Transmit enabled |
| rx_eof | input | 1 | Receive end-of-frame strobe |
| rx_len | input | LEN_W | Receive frame length in bytes, destination address through CRC |
| rx_good | input | 1 | Receive frame had no error |
| rx_addr_pass | input | 1 | Receive frame passed the address filter |
| rx_missed | input | 1 | Receive frame counted as missed |
| rx_fc | input | 1 | Receive frame is a flow-control frame |
| rx_buf_avail | input | 1 | A host receive buffer was available |
| tx_eof | input | 1 | Transmit end-of-frame strobe |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_good | input | 1 | Transmit frame was sent without error |
| tx_fc | input | 1 | Transmit frame is a flow-control frame |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register word address |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |

## Verification
The hardest condition to reach from the ports is saturation of a 64-bit octet counter, because frame lengths are far too small to fill it in a practical run. The bench therefore adds a second instance with a 40-bit counter and a 32-bit length field. It sends 256 maximum-length frames to land just under the limit, then one more to force the clamp, and then another to show that the counter holds. The same-cycle case of a high-half read and a counted frame is driven on purpose by raising both strobes in one cycle.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_RXO_LO = 3'd0,
        REG_RXO_HI = 3'd1,
        REG_TXO_LO = 3'd2,
        REG_TXO_HI = 3'd3,
        REG_NOBUF  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic rx_oct;
        logic tx_oct;
        logic nobuf;
    } qual_t;
endpackage

// File: rtl/mac_stat_qual.sv
module mac_stat_qual
    import mac_stat_pkg::*;
#(
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned MIN_TX_LEN = 64
) (
    input  logic             rx_enable,
    input  logic             tx_enable,
    input  logic             rx_eof,
    input  logic             rx_good,
    input  logic             rx_addr_pass,
    input  logic             rx_missed,
    input  logic             rx_fc,
    input  logic             rx_buf_avail,
    input  logic             tx_eof,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             tx_good,
    input  logic             tx_fc,
    output qual_t            qual
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_TX_LEN);

    logic rx_live;

    always_comb begin
        rx_live     = rx_eof && rx_enable && !rx_fc;
        qual.rx_oct = rx_live && rx_good && rx_addr_pass && !rx_missed;
        qual.nobuf  = rx_live && !rx_buf_avail;
        qual.tx_oct = tx_eof && tx_enable && tx_good && !tx_fc && (tx_len >= MIN_L);
    end
endmodule

// File: rtl/mac_stat_satcnt.sv
module mac_stat_satcnt #(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned INC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc_val,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam int unsigned SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          s_d, s_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end
        sum = {1'b0, s_d.cnt} + SUM_W'(inc_val);
        if (inc_en) begin
            s_d.cnt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/mac_stat_rdport.sv
module mac_stat_rdport
    import mac_stat_pkg::*;
#(
    parameter int unsigned OCT_W  = 64,
    parameter int unsigned NB_W   = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [OCT_W-1:0]  rx_cnt,
    input  logic [OCT_W-1:0]  tx_cnt,
    input  logic [NB_W-1:0]   nb_cnt,
    output logic              clr_rx,
    output logic              clr_tx,
    output logic              clr_nb,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned EXT_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_st_t;

    rd_st_t            s_d, s_q;
    logic [EXT_W-1:0]  rx_ext, tx_ext;

    always_comb begin
        rx_ext = EXT_W'(rx_cnt);
        tx_ext = EXT_W'(tx_cnt);
        clr_rx = 1'b0;
        clr_tx = 1'b0;
        clr_nb = 1'b0;
        s_d.data = '0;
        if (rd_en) begin
            case (rd_addr)
                REG_RXO_LO: s_d.data = rx_ext[DATA_W-1:0];
                REG_RXO_HI: begin
                    s_d.data = rx_ext[EXT_W-1:DATA_W];
                    clr_rx   = 1'b1;
                end
                REG_TXO_LO: s_d.data = tx_ext[DATA_W-1:0];
                REG_TXO_HI: begin
                    s_d.data = tx_ext[EXT_W-1:DATA_W];
                    clr_tx   = 1'b1;
                end
                REG_NOBUF: begin
                    s_d.data = DATA_W'(nb_cnt);
                    clr_nb   = 1'b1;
                end
                default: s_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.data;
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int unsigned OCT_W      = 64,
    parameter int unsigned NB_W       = 32,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned MIN_TX_LEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic              tx_enable,
    input  logic              rx_eof,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_good,
    input  logic              rx_addr_pass,
    input  logic              rx_missed,
    input  logic              rx_fc,
    input  logic              rx_buf_avail,
    input  logic              tx_eof,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_good,
    input  logic              tx_fc,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    qual_t            qual;
    logic             clr_rx, clr_tx, clr_nb;
    logic [OCT_W-1:0] rx_cnt, tx_cnt;
    logic [NB_W-1:0]  nb_cnt;

    mac_stat_qual #(.LEN_W(LEN_W), .MIN_TX_LEN(MIN_TX_LEN)) u_qual (
        .rx_enable   (rx_enable),
        .tx_enable   (tx_enable),
        .rx_eof      (rx_eof),
        .rx_good     (rx_good),
        .rx_addr_pass(rx_addr_pass),
        .rx_missed   (rx_missed),
        .rx_fc       (rx_fc),
        .rx_buf_avail(rx_buf_avail),
        .tx_eof      (tx_eof),
        .tx_len      (tx_len),
        .tx_good     (tx_good),
        .tx_fc       (tx_fc),
        .qual        (qual)
    );

    mac_stat_satcnt #(.CNT_W(OCT_W), .INC_W(LEN_W)) u_rx_oct (
        .clk(clk), .rst(rst), .inc_en(qual.rx_oct), .inc_val(rx_len),
        .clr(clr_rx), .cnt(rx_cnt)
    );

    mac_stat_satcnt #(.CNT_W(OCT_W), .INC_W(LEN_W)) u_tx_oct (
        .clk(clk), .rst(rst), .inc_en(qual.tx_oct), .inc_val(tx_len),
        .clr(clr_tx), .cnt(tx_cnt)
    );

    mac_stat_satcnt #(.CNT_W(NB_W), .INC_W(1)) u_nobuf (
        .clk(clk), .rst(rst), .inc_en(qual.nobuf), .inc_val(1'b1),
        .clr(clr_nb), .cnt(nb_cnt)
    );

    mac_stat_rdport #(.OCT_W(OCT_W), .NB_W(NB_W), .DATA_W(DATA_W)) u_rdport (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rx_cnt (rx_cnt),
        .tx_cnt (tx_cnt),
        .nb_cnt (nb_cnt),
        .clr_rx (clr_rx),
        .clr_tx (clr_tx),
        .clr_nb (clr_nb),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/mac_stat_bank_chk.sv
module mac_stat_bank_chk #(
    parameter int unsigned OCT_W      = 64,
    parameter int unsigned NB_W       = 32,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned MIN_TX_LEN = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_enable,
    input logic              rx_eof,
    input logic              tx_eof,
    input logic [LEN_W-1:0]  tx_len,
    input logic              rd_en,
    input logic [2:0]        rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [OCT_W-1:0]  rx_cnt,
    input logic [OCT_W-1:0]  tx_cnt,
    input logic [NB_W-1:0]   nb_cnt
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_TX_LEN);

    logic rd_rx_hi, rd_rx_lo, rd_tx_hi, rd_nb;
    assign rd_rx_lo = rd_en && (rd_addr == 3'd0);
    assign rd_rx_hi = rd_en && (rd_addr == 3'd1);
    assign rd_tx_hi = rd_en && (rd_addr == 3'd3);
    assign rd_nb    = rd_en && (rd_addr == 3'd4);

    // R5
    rx_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt == '1 && !rd_rx_hi) |=> rx_cnt == '1);

    // R3
    rx_hi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rx_hi && !rx_eof) |=> rx_cnt == '0);

    // R3
    rx_lo_no_side_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rx_lo && !rx_eof) |=> $stable(rx_cnt));

    // R7
    rx_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_enable && !rd_rx_hi) |=> $stable(rx_cnt));

    // R8
    tx_short_chk: assert property (@(posedge clk) disable iff (rst)
        (!(tx_eof && tx_len >= MIN_L) && !rd_tx_hi) |=> $stable(tx_cnt));

    // R2
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr > 3'd4) |=> rd_data == '0);

    // R2
    idle_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);

    // R9
    nobuf_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_nb |=> (nb_cnt == $past(nb_cnt)) || (nb_cnt == $past(nb_cnt) + NB_W'(1)));
endmodule

bind mac_stat_bank mac_stat_bank_chk #(
    .OCT_W(OCT_W), .NB_W(NB_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .MIN_TX_LEN(MIN_TX_LEN)
) u_chk (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .rx_eof(rx_eof),
    .tx_eof(tx_eof), .tx_len(tx_len), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .nb_cnt(nb_cnt)
);

// File: tb/test_mac_stat_bank.sv
module test_mac_stat_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_enable = 1'b1, tx_enable = 1'b1;
    logic        rx_eof = 1'b0, n_rx_eof = 1'b0;
    logic [31:0] rx_len = '0;
    logic        rx_good = 1'b1, rx_addr_pass = 1'b1, rx_missed = 1'b0;
    logic        rx_fc = 1'b0, rx_buf_avail = 1'b1;
    logic        tx_eof = 1'b0;
    logic [15:0] tx_len = '0;
    logic        tx_good = 1'b1, tx_fc = 1'b0;
    logic        rd_en = 1'b0, n_rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data, rd_data_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mac_stat_bank i_mac_stat_bank (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .tx_enable(tx_enable),
        .rx_eof(rx_eof), .rx_len(rx_len[15:0]), .rx_good(rx_good),
        .rx_addr_pass(rx_addr_pass), .rx_missed(rx_missed), .rx_fc(rx_fc),
        .rx_buf_avail(rx_buf_avail), .tx_eof(tx_eof), .tx_len(tx_len),
        .tx_good(tx_good), .tx_fc(tx_fc), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    mac_stat_bank #(.OCT_W(40), .NB_W(4), .LEN_W(32)) i_mac_stat_bank_narrow (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .tx_enable(tx_enable),
        .rx_eof(n_rx_eof), .rx_len(rx_len), .rx_good(rx_good),
        .rx_addr_pass(rx_addr_pass), .rx_missed(rx_missed), .rx_fc(rx_fc),
        .rx_buf_avail(rx_buf_avail), .tx_eof(1'b0), .tx_len(32'd0),
        .tx_good(1'b0), .tx_fc(1'b0), .rd_en(n_rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_rx(input logic g, p, m, f, b, en);
        rx_good = g; rx_addr_pass = p; rx_missed = m; rx_fc = f; rx_buf_avail = b; rx_enable = en;
    endtask

    task automatic rx_frame(input logic [31:0] len, input logic narrow);
        @(negedge clk);
        rx_len = len;
        if (narrow) n_rx_eof = 1'b1; else rx_eof = 1'b1;
        @(negedge clk);
        rx_eof = 1'b0; n_rx_eof = 1'b0;
    endtask

    task automatic tx_frame(input logic [15:0] len, input logic g, f, en);
        @(negedge clk);
        tx_len = len; tx_good = g; tx_fc = f; tx_enable = en; tx_eof = 1'b1;
        @(negedge clk);
        tx_eof = 1'b0; tx_good = 1'b1; tx_fc = 1'b0; tx_enable = 1'b1;
    endtask

    task automatic rd(input logic [2:0] a, input logic narrow, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        if (narrow) n_rd_en = 1'b1; else rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; n_rd_en = 1'b0;
        d = narrow ? rd_data_n : rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R2 idle data", rd_data, 32'h0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), 1'b0, d);
            check("R1 reset value", d, 32'h0);
        end
    endtask

    task automatic t_rx_basic();
        logic [31:0] d;
        set_rx(1, 1, 0, 0, 1, 1);
        rx_frame(64, 0); rx_frame(1518, 0); rx_frame(100, 0);
        rd(3'd0, 0, d); check("R6 rx sum", d, 32'd1682);
        rd(3'd0, 0, d); check("R3 low read keeps", d, 32'd1682);
        rd(3'd1, 0, d); check("R3 high half", d, 32'd0);
        rd(3'd0, 0, d); check("R3 cleared after high read", d, 32'd0);
    endtask

    task automatic t_rx_reject();
        logic [31:0] d;
        set_rx(0, 1, 0, 0, 1, 1); rx_frame(200, 0);
        set_rx(1, 0, 0, 0, 1, 1); rx_frame(200, 0);
        set_rx(1, 1, 1, 0, 1, 1); rx_frame(200, 0);
        set_rx(1, 1, 0, 1, 1, 1); rx_frame(200, 0);
        set_rx(1, 1, 0, 0, 1, 0); rx_frame(200, 0);
        set_rx(1, 1, 0, 0, 1, 1);
        rd(3'd0, 0, d); check("R7 rejected frames", d, 32'd0);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        tx_frame(64, 1, 0, 1);
        tx_frame(63, 1, 0, 1);
        tx_frame(300, 1, 1, 1);
        tx_frame(300, 0, 0, 1);
        tx_frame(300, 1, 0, 0);
        tx_frame(200, 1, 0, 1);
        rd(3'd2, 0, d); check("R8 tx sum", d, 32'd264);
        rd(3'd3, 0, d); check("R8 tx high", d, 32'd0);
        rd(3'd2, 0, d); check("R3 tx cleared", d, 32'd0);
    endtask

    task automatic t_nobuf();
        logic [31:0] d;
        set_rx(0, 1, 0, 0, 0, 1); rx_frame(80, 0);
        set_rx(1, 1, 0, 1, 0, 1); rx_frame(80, 0);
        set_rx(1, 1, 0, 0, 0, 0); rx_frame(80, 0);
        set_rx(1, 1, 0, 0, 0, 1); rx_frame(80, 0);
        set_rx(1, 1, 0, 0, 1, 1);
        rd(3'd4, 0, d); check("R9 nobuf count", d, 32'd2);
        rd(3'd4, 0, d); check("R9 nobuf cleared", d, 32'd0);
        rd(3'd0, 0, d); check("R6 rx with no buffer", d, 32'd80);
        rd(3'd1, 0, d);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rx_frame(10, 0);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), 0, d); check("R2 unmapped zero", d, 32'd0);
        end
        rd(3'd0, 0, d); check("R2 unmapped no side effect", d, 32'd10);
        rd(3'd1, 0, d);
    endtask

    task automatic t_clr_inc();
        logic [31:0] d;
        rx_frame(500, 0);
        @(negedge clk);
        rx_len = 40; rx_eof = 1'b1; rd_addr = 3'd1; rd_en = 1'b1;
        @(negedge clk);
        rx_eof = 1'b0; rd_en = 1'b0;
        check("R4 high half on collision", rd_data, 32'd0);
        rd(3'd0, 0, d); check("R4 frame kept across clear", d, 32'd40);
        rd(3'd1, 0, d);
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        for (int i = 0; i < 256; i++) rx_frame(32'hFFFF_FFFF, 1);
        rd(3'd0, 1, d); check("R5 near max low", d, 32'hFFFF_FF00);
        rd(3'd1, 1, d); check("R3 high half before clear", d, 32'h0000_00FF);
        rd(3'd0, 1, d); check("R3 narrow cleared", d, 32'h0);
        for (int i = 0; i < 256; i++) rx_frame(32'hFFFF_FFFF, 1);
        rx_frame(32'hFFFF_FFFF, 1);
        rd(3'd0, 1, d); check("R5 clamp low", d, 32'hFFFF_FFFF);
        rx_frame(32'h0000_0010, 1);
        rd(3'd0, 1, d); check("R5 hold low", d, 32'hFFFF_FFFF);
        rd(3'd1, 1, d); check("R5 hold high", d, 32'h0000_00FF);
        set_rx(0, 1, 0, 0, 0, 1);
        for (int i = 0; i < 17; i++) rx_frame(32'd1, 1);
        set_rx(1, 1, 0, 0, 1, 1);
        rd(3'd4, 1, d); check("R9 R5 nobuf saturates", d, 32'd15);
        rd(3'd4, 1, d); check("R9 nobuf cleared", d, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rx_basic();
        t_rx_reject();
        t_tx();
        t_nobuf();
        t_unmapped();
        t_clr_inc();
        t_saturate();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule